// File: doc/BRIEF.md
# Indirect Command Register Bridge

This block puts a bank of byte-wide configuration and status registers of a two-wire serial controller behind one 64-bit command word. Software writes the whole word at once: an operation code, a register selector, a read/write flag, a data field and a valid flag. When the valid flag is set and the operation code selects direct register access, the bridge runs one internal register access. It clears the valid flag when that access ends. Software polls the word until the flag reads zero. On a read, the selected byte then sits in the low data bits.

The internal registers are a local slave address, an extended slave address, a data byte, a control byte, a clock-divider byte and a status byte. Each one drives an output port toward the byte engine. The status byte can also be loaded by that engine. The serial bus logic itself lies outside this block.

Top module: `ser_cmd_bridge`

## Requirements
- R1: After reset the command word reads all zeros. The slave address, extended slave address, data, control and clock-divider registers read 0x00, and the status register reads the idle code 0xF8.
- R2: The command word fields are: valid flag in bit 63, read flag in bit 56, operation code in bits [60:57], register selector in bits [34:32], write byte in bits [7:0], and the data field in bits [31:0]. Operation code 6 means direct register access.
- R3: A host write that sets valid and carries operation code 6, accepted while valid is clear, keeps valid reading 1 for exactly ACC_LAT (default 2) clock cycles. Valid then reads 0.
- R4: A direct write access stores bits [7:0] into the selected register: selector 0 is the slave address, 1 data, 2 control, 3 clock divider, 4 extended slave address. The other registers are left unchanged.
- R5: A direct read access places the selected register's byte in bits [7:0] and clears bits [31:8]. Bits [62:32] keep the values that were written.
- R6: Selector 3 reads return the status register. Selector 3 writes go to the clock divider and leave the status register unchanged.
- R7: A host write that arrives while valid reads 1 is ignored. The running access completes with its own fields and data.
- R8: A host write with valid set and an operation code other than 6 completes at once. On the next cycle the word reads valid 0 with the other bits as written, and no register changes.
- R9: A direct write to selector 7 is a soft reset: control goes to 0x00 and status to 0xF8, and the other registers keep their values. Direct reads of selectors 5, 6 and 7 return 0x00.
- R10: A pulse on the engine status load input stores its byte into the status register, where a selector 3 read returns it.
- R11: A host write with valid clear stores the word unchanged and performs no register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| cmd_word | output | 64 | Current command word, polled by the host |
| eng_stat_we | input | 1 | Byte engine status load strobe |
| eng_stat | input | 8 | Status byte from the byte engine |
| reg_saddr | output | 8 | Local slave address register |
| reg_saddr_x | output | 8 | Extended slave address register |
| reg_data | output | 8 | Data register |
| reg_ctrl | output | 8 | Control register |
| reg_clkdiv | output | 8 | Clock divider register |
| reg_stat | output | 8 | Status register |

## Verification
A wrong latency counter or a stuck busy state shows in the first poll sequence. Valid then reads 1 for the wrong number of cycles, or never clears, within ACC_LAT+1 cycles of the launch. A selector decode error puts the byte into the wrong register output on the cycle the access ends, and the register port checks after each command catch it. A read mux error shows in the low byte of the word at that same edge. A failure to ignore busy writes, or to preserve the upper fields, changes the completed word that the scoreboard compares.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int WORD_W    = 64;
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int OP_W      = 4;
    localparam int VALID_BIT = 63;
    localparam int RD_BIT    = 56;
    localparam int OP_LO     = 57;
    localparam int SEL_LO    = 32;
    localparam logic [OP_W-1:0]   OP_DIRECT = 4'd6;
    localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hF8;

    typedef enum logic [SEL_W-1:0] {
        SEL_SADDR   = 3'd0,
        SEL_DATA    = 3'd1,
        SEL_CTRL    = 3'd2,
        SEL_CLKSTAT = 3'd3,
        SEL_SADDR_X = 3'd4,
        SEL_SPARE5  = 3'd5,
        SEL_SPARE6  = 3'd6,
        SEL_SRST    = 3'd7
    } sel_e;

    typedef struct packed {
        logic              launch;
        logic              direct;
        logic              rd;
        sel_e              sel;
        logic [BYTE_W-1:0] wbyte;
    } cmd_dec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] saddr;
        logic [BYTE_W-1:0] saddr_x;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] clkdiv;
        logic [BYTE_W-1:0] stat;
    } reg_bank_t;
endpackage

// File: rtl/scb_decode.sv
module scb_decode
    import scb_pkg::*;
(
    input  logic              valid_f,
    input  logic              rd_f,
    input  logic [OP_W-1:0]   op_f,
    input  logic [SEL_W-1:0]  sel_f,
    input  logic [BYTE_W-1:0] byte_f,
    output cmd_dec_t          dec
);
    always_comb begin
        dec.launch = valid_f;
        dec.direct = (op_f == OP_DIRECT);
        dec.rd     = rd_f;
        dec.sel    = sel_e'(sel_f);
        dec.wbyte  = byte_f;
    end
endmodule

// File: rtl/scb_seq.sv
module scb_seq
    import scb_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [BYTE_W-1:0] acc_rbyte,
    output logic [WORD_W-1:0] cmd_word,
    output logic              acc_fire,
    output logic              acc_rd,
    output sel_e              acc_sel,
    output logic [BYTE_W-1:0] acc_wbyte
);
    localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_LAT - 1);

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t     s_d, s_q;
    cmd_dec_t cur;
    logic     hst_launch, hst_direct;

    scb_decode u_dec_cur (
        .valid_f (s_q.cmd[VALID_BIT]),
        .rd_f    (s_q.cmd[RD_BIT]),
        .op_f    (s_q.cmd[OP_LO +: OP_W]),
        .sel_f   (s_q.cmd[SEL_LO +: SEL_W]),
        .byte_f  (s_q.cmd[BYTE_W-1:0]),
        .dec     (cur)
    );

    assign hst_launch = host_wdata[VALID_BIT];
    assign hst_direct = (host_wdata[OP_LO +: OP_W] == OP_DIRECT);

    always_comb begin
        s_d      = s_q;
        acc_fire = 1'b0;
        if (cur.launch && cur.direct) begin
            if (s_q.cnt == '0) begin
                acc_fire             = 1'b1;
                s_d.cmd[VALID_BIT]   = 1'b0;
                if (cur.rd)
                    s_d.cmd[DATA_W-1:0] = {{(DATA_W-BYTE_W){1'b0}}, acc_rbyte};
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (host_we) begin
            s_d.cmd = host_wdata;
            if (hst_launch) begin
                if (hst_direct)
                    s_d.cnt = CNT_LOAD;
                else
                    s_d.cmd[VALID_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_word  = s_q.cmd;
    assign acc_rd    = cur.rd;
    assign acc_sel   = cur.sel;
    assign acc_wbyte = cur.wbyte;

    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_word[VALID_BIT] && host_we && host_wdata[VALID_BIT] && hst_direct)
        |=> cmd_word[VALID_BIT]);

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[VALID_BIT] && host_we)
        |=> (cmd_word[62:DATA_W] == $past(cmd_word[62:DATA_W])));

    assert_quick_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_word[VALID_BIT] && host_we && host_wdata[VALID_BIT] && !hst_direct)
        |=> (!cmd_word[VALID_BIT] && cmd_word[62:0] == $past(host_wdata[62:0])));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && acc_rd)
        |=> (!cmd_word[VALID_BIT] && cmd_word[DATA_W-1:BYTE_W] == '0));
endmodule

// File: rtl/scb_regbank.sv
module scb_regbank
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic              acc_rd,
    input  sel_e              acc_sel,
    input  logic [BYTE_W-1:0] acc_wbyte,
    input  logic              eng_stat_we,
    input  logic [BYTE_W-1:0] eng_stat,
    output logic [BYTE_W-1:0] acc_rbyte,
    output reg_bank_t         regs
);
    reg_bank_t r_d, r_q;
    logic      wr_go;

    assign wr_go = acc_fire && !acc_rd;

    always_comb begin
        r_d = r_q;
        if (eng_stat_we) r_d.stat = eng_stat;
        if (wr_go) begin
            unique case (acc_sel)
                SEL_SADDR:   r_d.saddr   = acc_wbyte;
                SEL_DATA:    r_d.data    = acc_wbyte;
                SEL_CTRL:    r_d.ctrl    = acc_wbyte;
                SEL_CLKSTAT: r_d.clkdiv  = acc_wbyte;
                SEL_SADDR_X: r_d.saddr_x = acc_wbyte;
                SEL_SRST: begin
                    r_d.ctrl = '0;
                    r_d.stat = STAT_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (acc_sel)
            SEL_SADDR:   acc_rbyte = r_q.saddr;
            SEL_DATA:    acc_rbyte = r_q.data;
            SEL_CTRL:    acc_rbyte = r_q.ctrl;
            SEL_CLKSTAT: acc_rbyte = r_q.stat;
            SEL_SADDR_X: acc_rbyte = r_q.saddr_x;
            default:     acc_rbyte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.stat <= STAT_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && acc_sel == SEL_SRST)
        |=> (r_q.ctrl == '0 && r_q.stat == STAT_IDLE));

    assert_data_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && acc_sel == SEL_DATA) |=> (r_q.data == $past(acc_wbyte)));

    assert_stat_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && acc_sel == SEL_CLKSTAT && !eng_stat_we) |=> $stable(r_q.stat));
endmodule

// File: rtl/ser_cmd_bridge.sv
module ser_cmd_bridge
    import scb_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [63:0] host_wdata,
    output logic [63:0] cmd_word,
    input  logic        eng_stat_we,
    input  logic [7:0]  eng_stat,
    output logic [7:0]  reg_saddr,
    output logic [7:0]  reg_saddr_x,
    output logic [7:0]  reg_data,
    output logic [7:0]  reg_ctrl,
    output logic [7:0]  reg_clkdiv,
    output logic [7:0]  reg_stat
);
    logic              acc_fire, acc_rd;
    sel_e              acc_sel;
    logic [BYTE_W-1:0] acc_wbyte, acc_rbyte;
    reg_bank_t         regs;

    scb_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .acc_rbyte  (acc_rbyte),
        .cmd_word   (cmd_word),
        .acc_fire   (acc_fire),
        .acc_rd     (acc_rd),
        .acc_sel    (acc_sel),
        .acc_wbyte  (acc_wbyte)
    );

    scb_regbank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_fire    (acc_fire),
        .acc_rd      (acc_rd),
        .acc_sel     (acc_sel),
        .acc_wbyte   (acc_wbyte),
        .eng_stat_we (eng_stat_we),
        .eng_stat    (eng_stat),
        .acc_rbyte   (acc_rbyte),
        .regs        (regs)
    );

    assign reg_saddr   = regs.saddr;
    assign reg_saddr_x = regs.saddr_x;
    assign reg_data    = regs.data;
    assign reg_ctrl    = regs.ctrl;
    assign reg_clkdiv  = regs.clkdiv;
    assign reg_stat    = regs.stat;
endmodule

// File: tb/tb_ser_cmd_bridge.sv
`timescale 1ns/1ps
module tb_ser_cmd_bridge;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] cmd_word;
    logic        eng_stat_we = 1'b0;
    logic [7:0]  eng_stat = '0;
    logic [7:0]  reg_saddr, reg_saddr_x, reg_data, reg_ctrl, reg_clkdiv, reg_stat;

    always #2.5 clk = ~clk;

    ser_cmd_bridge #(.ACC_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .cmd_word(cmd_word), .eng_stat_we(eng_stat_we), .eng_stat(eng_stat),
        .reg_saddr(reg_saddr), .reg_saddr_x(reg_saddr_x), .reg_data(reg_data),
        .reg_ctrl(reg_ctrl), .reg_clkdiv(reg_clkdiv), .reg_stat(reg_stat)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;
    bit pend = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    // reference register model, updated from the requirements
    logic [7:0] m_sa = 8'h00, m_sx = 8'h00, m_dat = 8'h00;
    logic [7:0] m_ctl = 8'h00, m_clk = 8'h00, m_st = 8'hF8;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit v, input bit rd, input logic [3:0] op,
                                       input logic [2:0] sel, input logic [31:0] d,
                                       input logic [9:0] ba);
        logic [63:0] w;
        w = '0;
        w[63] = v; w[56] = rd; w[60:57] = op; w[34:32] = sel;
        w[49:40] = ba; w[54:52] = 3'd5; w[31:0] = d;
        return w;
    endfunction

    function automatic logic [7:0] mread(input logic [2:0] sel);
        case (sel)
            3'd0: return m_sa;
            3'd1: return m_dat;
            3'd2: return m_ctl;
            3'd3: return m_st;
            3'd4: return m_sx;
            default: return 8'h00;
        endcase
    endfunction

    task automatic mwrite(input logic [2:0] sel, input logic [7:0] b);
        case (sel)
            3'd0: m_sa = b;
            3'd1: m_dat = b;
            3'd2: m_ctl = b;
            3'd3: m_clk = b;
            3'd4: m_sx = b;
            3'd7: begin m_ctl = 8'h00; m_st = 8'hF8; end
            default: ;
        endcase
    endtask

    // expected completed word plus model update (R2 field positions)
    task automatic predict(input logic [63:0] w, output logic [63:0] e, output int lat);
        e = w; lat = 0;
        if (w[63]) begin
            e[63] = 1'b0;
            if (w[60:57] == 4'd6) begin
                lat = LAT;
                if (w[56]) e[31:0] = {24'h0, mread(w[34:32])};
                else       mwrite(w[34:32], w[7:0]);
            end
        end
    endtask

    task automatic check_regs(input string rq);
        chk({rq, " saddr"},   {56'h0, reg_saddr},   {56'h0, m_sa});
        chk({rq, " saddr_x"}, {56'h0, reg_saddr_x}, {56'h0, m_sx});
        chk({rq, " data"},    {56'h0, reg_data},    {56'h0, m_dat});
        chk({rq, " ctrl"},    {56'h0, reg_ctrl},    {56'h0, m_ctl});
        chk({rq, " clkdiv"},  {56'h0, reg_clkdiv},  {56'h0, m_clk});
        chk({rq, " stat"},    {56'h0, reg_stat},    {56'h0, m_st});
    endtask

    // driver: launches one command, pushes expectation, counts poll cycles
    task automatic issue(input logic [63:0] w, input string rq);
        logic [63:0] e;
        int lat;
        int n;
        predict(w, e, lat);
        exp_q.push_back(e);
        tag_q.push_back(rq);
        @(negedge clk); host_we = 1'b1; host_wdata = w;
        @(negedge clk); host_we = 1'b0; pend = 1'b1;
        n = 0;
        while (cmd_word[63] && n < 16) begin n++; @(negedge clk); end
        chk({rq, " R3 busy cycles"}, 64'(n), 64'(lat));
        wait (pend == 1'b0);
        check_regs(rq);
    endtask

    // monitor: pops expectation once the word shows completion
    initial begin
        forever begin
            @(negedge clk);
            if (pend && !cmd_word[63]) begin
                chk({tag_q.pop_front(), " word"}, cmd_word, exp_q.pop_front());
                pend = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [63:0] w1, w2, e1;
        int lat1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", cmd_word, 64'h0);
        check_regs("R1 reset");

        // direct writes (R2/R4), clock divider via selector 3 (R6)
        issue(mk(1, 0, 4'd6, 3'd0, 32'h0000_0077, 10'h155), "R4 saddr write");
        issue(mk(1, 0, 4'd6, 3'd1, 32'h1234_56A5, 10'h0AA), "R2/R4 data write");
        issue(mk(1, 0, 4'd6, 3'd2, 32'h0000_0044, 10'h001), "R4 ctrl write");
        issue(mk(1, 0, 4'd6, 3'd4, 32'h0000_003C, 10'h3FF), "R4 saddr_x write");
        issue(mk(1, 0, 4'd6, 3'd3, 32'h0000_005B, 10'h200), "R6 clkdiv write");

        // direct reads (R5), status via selector 3 (R6)
        issue(mk(1, 1, 4'd6, 3'd0, 32'hDEAD_BE00, 10'h2A5), "R5 read saddr");
        issue(mk(1, 1, 4'd6, 3'd1, 32'hFFFF_FFFF, 10'h123), "R5 read data");
        issue(mk(1, 1, 4'd6, 3'd2, 32'h0000_0000, 10'h000), "R5 read ctrl");
        issue(mk(1, 1, 4'd6, 3'd3, 32'hA5A5_A5A5, 10'h0F0), "R6 read status");
        issue(mk(1, 1, 4'd6, 3'd4, 32'h0101_0101, 10'h30C), "R5 read saddr_x");

        // other opcodes complete at once (R8)
        issue(mk(1, 0, 4'd0, 3'd2, 32'h0000_0099, 10'h011), "R8 op0 no effect");
        issue(mk(1, 1, 4'd1, 3'd1, 32'h0000_0033, 10'h022), "R8 op1 no effect");

        // valid clear: stored, nothing done (R11)
        issue(mk(0, 0, 4'd6, 3'd1, 32'h0000_00EE, 10'h0C3), "R11 no launch");

        // busy write ignored (R7)
        w1 = mk(1, 0, 4'd6, 3'd1, 32'h0000_0012, 10'h111);
        w2 = mk(1, 0, 4'd6, 3'd2, 32'h0000_00EE, 10'h222);
        predict(w1, e1, lat1);
        exp_q.push_back(e1);
        tag_q.push_back("R7 busy write");
        @(negedge clk); host_we = 1'b1; host_wdata = w1;
        @(negedge clk); host_wdata = w2;
        @(negedge clk); host_we = 1'b0; pend = 1'b1;
        wait (pend == 1'b0);
        check_regs("R7 busy write");

        // engine status load (R10)
        @(negedge clk); eng_stat_we = 1'b1; eng_stat = 8'h28;
        @(negedge clk); eng_stat_we = 1'b0; m_st = 8'h28;
        chk("R10 stat port", {56'h0, reg_stat}, 64'h28);
        issue(mk(1, 1, 4'd6, 3'd3, 32'h0, 10'h0), "R10 read status");

        // soft reset and spare selectors (R9)
        issue(mk(1, 0, 4'd6, 3'd7, 32'h0000_00FF, 10'h0), "R9 soft reset");
        issue(mk(1, 1, 4'd6, 3'd7, 32'h0000_00FF, 10'h0), "R9 read sel7");
        issue(mk(1, 1, 4'd6, 3'd5, 32'h0000_1234, 10'h0), "R9 read sel5");
        issue(mk(1, 1, 4'd6, 3'd6, 32'h0000_5678, 10'h0), "R9 read sel6");
        issue(mk(1, 1, 4'd6, 3'd3, 32'h0, 10'h0), "R9 status idle");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule